// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Modes

This block is a general-purpose I/O unit on a 16-bit register bus. It has 32 bidirectional pins. Each of them has its own direction, output value, pull control, interrupt enable and interrupt mode. A second bank of 18 output-only pins has its own output register. Each 32-bit control word is reached as two 16-bit words. Each word is written on its own.

Each input passes through a two-flop synchronizer. An input pin can raise a status bit on either edge or on a level. In level mode a per-pin polarity decides which level counts. Each pin selects latched (hold) or transparent (through) status. Latched status stays set until software writes a one to it. The single interrupt request is the OR over all pins of status ANDed with enable.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe_o`=0) and all output, pull, enable and status bits are 0, so `irq_o`=0. While every input sits at its inactive level, status stays 0 through the first cycles after reset, while the synchronizer fills.
- R2: The word address is 2*index+half. Half 0 holds bits 15:0 and half 1 holds bits 31:16. The register indices are: data 0, output-only bank 1, direction 2, enable 3, status 4, trigger 5, level 6, hold 7, pull-enable 8, pull-select 9. A write to one half leaves the other half unchanged.
- R3: `pin_oe_o` follows the direction register (1 = output). A write to the data register sets `pin_out_o`. A read of the data register returns the output value for output pins and the synchronized input for input pins.
- R4: Bit n of the output-only bank drives `hi_out_o[n]`, for n from 0 to 17. Its bits above 17 read back 0. Writes to it never set a status bit. `hi_out_o` changes only on a write to index 1.
- R5: With trigger bit 1 (edge), a rising or falling change on an input pin sets its status bit. The bit is visible after the third rising clock edge that follows the change.
- R6: With trigger bit 0 (level), the condition is true while the synchronized input equals the level bit (1 = active-high, 0 = active-low).
- R7: With hold bit 1, a status bit stays set after its condition ends, until it is cleared.
- R8: With hold bit 0, status follows the live condition. An edge then gives a status pulse one cycle long.
- R9: Status is write-one-to-clear. Zero bits in the written word have no effect. An event in the same cycle as a clear wins, and the bit stays set.
- R10: `irq_o` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: A pin configured as an output never sets its status bit.
- R12: Pull-enable bits drive `pull_en_o` and pull-select bits drive `pull_up_o` (1 = pull-up, 0 = pull-down).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 5 | Word address (2*index+half) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed word (combinational) |
| pin_in_i | input | 32 | Levels of the bidirectional pins |
| pin_out_o | output | 32 | Output values of the bidirectional pins |
| pin_oe_o | output | 32 | Output enables (1 = pin drives) |
| hi_out_o | output | 18 | Output-only bank |
| pull_en_o | output | 32 | Pull resistor enable per pin |
| pull_up_o | output | 32 | Pull direction per pin (1 = up) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that reset is held low from time zero across at least one clock edge. They also assume that at most one register word is written per cycle, so a clear and a configuration change never arrive together on the same bit. The bench holds reset for several cycles and issues each bus write in its own cycle. It changes pin levels only on falling clock edges and holds each level for at least three cycles, so every change passes the synchronizer before the next one. Changes of configuration are made only while the affected pin is stable, so they never create a spurious edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    REG_DATA  = 4'd0,
    REG_HIOUT = 4'd1,
    REG_DIR   = 4'd2,
    REG_IEN   = 4'd3,
    REG_STAT  = 4'd4,
    REG_TRIG  = 4'd5,
    REG_LVL   = 4'd6,
    REG_HOLD  = 4'd7,
    REG_PEN   = 4'd8,
    REG_PSEL  = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] sync_o,
  output logic [NPIN-1:0] prev_o,
  output logic            valid_o
);
  localparam int unsigned WARM = STAGES + 1;
  localparam int unsigned CW   = $clog2(WARM + 1);

  logic [NPIN-1:0] stg_q [STAGES];
  logic [NPIN-1:0] prev_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
      if (cnt_q != CW'(WARM)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o  = stg_q[STAGES-1];
  assign prev_o  = prev_q;
  // pipeline holds reset values until filled; block detection until then
  assign valid_o = (cnt_q == CW'(WARM));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] trig_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] hold_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] stat_o
);
  logic [NPIN-1:0] ev;
  logic [NPIN-1:0] stat_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic edge_hit, lvl_hit;
    assign edge_hit = sync_i[i] ^ prev_i[i];
    assign lvl_hit  = ~(sync_i[i] ^ lvl_i[i]);
    assign ev[i]    = valid_i & ~dir_i[i] & (trig_i[i] ? edge_hit : lvl_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (hold_i & ((stat_q & ~clr_i) | ev)) | (~hold_i & ev);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned NOUT   = 18,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [NPIN-1:0]   pin_lvl_i,
  input  logic [NPIN-1:0]   stat_i,
  output logic [NPIN-1:0]   dout_o,
  output logic [NOUT-1:0]   hout_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   ien_o,
  output logic [NPIN-1:0]   trig_o,
  output logic [NPIN-1:0]   lvl_o,
  output logic [NPIN-1:0]   hold_o,
  output logic [NPIN-1:0]   pen_o,
  output logic [NPIN-1:0]   psel_o,
  output logic [NPIN-1:0]   clr_o
);
  localparam logic [NPIN-1:0] HOUT_MASK = NPIN'((64'd1 << NOUT) - 64'd1);

  reg_idx_e idx;
  logic     hi;
  assign idx = reg_idx_e'(addr_i[ADDR_W-1:1]);
  assign hi  = addr_i[0];

  function automatic logic [NPIN-1:0] merge(input logic [NPIN-1:0] old,
                                            input logic [BUS_W-1:0] d,
                                            input logic h);
    merge = h ? {d, old[BUS_W-1:0]} : {old[NPIN-1:BUS_W], d};
  endfunction

  logic [NPIN-1:0] dout_q, hout_q, dir_q, ien_q, trig_q, lvl_q, hold_q, pen_q, psel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0; hout_q <= '0; dir_q <= '0; ien_q  <= '0; trig_q <= '0;
      lvl_q  <= '0; hold_q <= '0; pen_q <= '0; psel_q <= '0;
    end else if (wr_en_i) begin
      case (idx)
        REG_DATA:  dout_q <= merge(dout_q, wdata_i, hi);
        REG_HIOUT: hout_q <= merge(hout_q, wdata_i, hi) & HOUT_MASK;
        REG_DIR:   dir_q  <= merge(dir_q,  wdata_i, hi);
        REG_IEN:   ien_q  <= merge(ien_q,  wdata_i, hi);
        REG_TRIG:  trig_q <= merge(trig_q, wdata_i, hi);
        REG_LVL:   lvl_q  <= merge(lvl_q,  wdata_i, hi);
        REG_HOLD:  hold_q <= merge(hold_q, wdata_i, hi);
        REG_PEN:   pen_q  <= merge(pen_q,  wdata_i, hi);
        REG_PSEL:  psel_q <= merge(psel_q, wdata_i, hi);
        default: ;
      endcase
    end
  end

  // status is not stored here: a write produces a one-cycle clear mask
  always_comb begin
    clr_o = '0;
    if (wr_en_i && idx == REG_STAT)
      clr_o = hi ? {wdata_i, {BUS_W{1'b0}}} : {{BUS_W{1'b0}}, wdata_i};
  end

  logic [NPIN-1:0] sel;
  always_comb begin
    case (idx)
      REG_DATA:  sel = pin_lvl_i;
      REG_HIOUT: sel = hout_q;
      REG_DIR:   sel = dir_q;
      REG_IEN:   sel = ien_q;
      REG_STAT:  sel = stat_i;
      REG_TRIG:  sel = trig_q;
      REG_LVL:   sel = lvl_q;
      REG_HOLD:  sel = hold_q;
      REG_PEN:   sel = pen_q;
      REG_PSEL:  sel = psel_q;
      default:   sel = '0;
    endcase
    rdata_o = hi ? sel[NPIN-1:BUS_W] : sel[BUS_W-1:0];
  end

  assign dout_o = dout_q;
  assign hout_o = hout_q[NOUT-1:0];
  assign dir_o  = dir_q;
  assign ien_o  = ien_q;
  assign trig_o = trig_q;
  assign lvl_o  = lvl_q;
  assign hold_o = hold_q;
  assign pen_o  = pen_q;
  assign psel_o = psel_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPIN        = 32,
  parameter int unsigned NOUT        = 18,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [NPIN-1:0]   pin_in_i,
  output logic [NPIN-1:0]   pin_out_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [NOUT-1:0]   hi_out_o,
  output logic [NPIN-1:0]   pull_en_o,
  output logic [NPIN-1:0]   pull_up_o,
  output logic              irq_o
);
  logic [NPIN-1:0] sync_w, prev_w, dout_w, dir_w, ien_w, trig_w, lvl_w, hold_w, clr_w, stat_w;
  logic [NPIN-1:0] pin_lvl_w;
  logic            valid_w;

  gpio_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_in_i),
    .sync_o(sync_w), .prev_o(prev_w), .valid_o(valid_w)
  );

  assign pin_lvl_w = (dir_w & dout_w) | (~dir_w & sync_w);

  gpio_regs #(.NPIN(NPIN), .NOUT(NOUT), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_lvl_i(pin_lvl_w), .stat_i(stat_w),
    .dout_o(dout_w), .hout_o(hi_out_o), .dir_o(dir_w), .ien_o(ien_w),
    .trig_o(trig_w), .lvl_o(lvl_w), .hold_o(hold_w), .pen_o(pull_en_o),
    .psel_o(pull_up_o), .clr_o(clr_w)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_w), .sync_i(sync_w),
    .prev_i(prev_w), .dir_i(dir_w), .trig_i(trig_w), .lvl_i(lvl_w),
    .hold_i(hold_w), .clr_i(clr_w), .stat_o(stat_w)
  );

  assign pin_out_o = dout_w;
  assign pin_oe_o  = dir_w;
  assign irq_o     = |(stat_w & ien_w);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned NOUT   = 18,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic [NOUT-1:0]   hi_out_o,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   ien,
  input logic [NPIN-1:0]   dir,
  input logic [NPIN-1:0]   hold,
  input logic [NPIN-1:0]   clr
);
  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o);

  assert_hold_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat & hold & ~clr) & ~stat) == '0));

  assert_outpin_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(dir) & stat & ~$past(stat)) == '0));

  assert_hibank_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i[ADDR_W-1:1] == (ADDR_W-1)'(gpio_pkg::REG_HIOUT)) |=> $stable(hi_out_o));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPIN(NPIN), .NOUT(NOUT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .irq_o(irq_o), .hi_out_o(hi_out_o), .stat(stat_w), .ien(ien_w),
  .dir(dir_w), .hold(hold_w), .clr(clr_w)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [31:0] pin_in_i = '1;
  logic [31:0] pin_out_o, pin_oe_o, pull_en_o, pull_up_o;
  logic [17:0] hi_out_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  gpio_irq_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .hi_out_o(hi_out_o),
    .pull_en_o(pull_en_o), .pull_up_o(pull_up_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i); addr_i = a; wr_en_i = 1'b0;
    #1 d = rdata_o;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk(pin_oe_o, 32'h0, "R1 oe");
    chk(pin_out_o, 32'h0, "R1 out");
    chk({14'h0, hi_out_o}, 32'h0, "R1 hi bank");
    chk(pull_en_o | pull_up_o, 32'h0, "R1 pull");
    chk({31'h0, irq_o}, 32'h0, "R1 irq");
    rd(8, d); chk({16'h0, d}, 32'h0, "R1 status lo");
    rd(9, d); chk({16'h0, d}, 32'h0, "R1 status hi");
  endtask

  task automatic t_halves;
    logic [15:0] d;
    wr(4, 16'h00FF); chk(pin_oe_o, 32'h000000FF, "R3 dir lo");
    wr(5, 16'hA500); chk(pin_oe_o, 32'hA50000FF, "R2 hi half keeps lo");
    wr(0, 16'h1234); wr(1, 16'h8000);
    chk(pin_out_o, 32'h80001234, "R3 data out");
    rd(0, d); chk({16'h0, d}, 32'h0000FF34, "R3 data read lo mix");
    rd(1, d); chk({16'h0, d}, 32'h0000DAFF, "R3 data read hi mix");
    rd(5, d); chk({16'h0, d}, 32'h0000A500, "R2 dir hi readback");
    wr(4, 16'h0); wr(5, 16'h0);
    chk(pin_oe_o, 32'h0, "R3 dir cleared");
  endtask

  task automatic t_hibank;
    logic [15:0] d;
    wr(2, 16'hBEEF); wr(3, 16'hFFFF);
    chk({14'h0, hi_out_o}, 32'h0003BEEF, "R4 hi bank drive");
    rd(3, d); chk({16'h0, d}, 32'h00000003, "R4 hi bank upper bits");
    rd(8, d); chk({16'h0, d}, 32'h0, "R4 no status lo");
    rd(9, d); chk({16'h0, d}, 32'h0, "R4 no status hi");
  endtask

  task automatic t_pull;
    wr(16, 16'h0F0F); wr(19, 16'h8001);
    chk(pull_en_o, 32'h00000F0F, "R12 pull enable");
    chk(pull_up_o, 32'h80010000, "R12 pull select");
  endtask

  task automatic t_edge_hold;
    logic [15:0] d;
    wr(10, 16'h0008); wr(14, 16'h0008); wr(6, 16'h0008);
    chk({31'h0, irq_o}, 32'h0, "R10 idle irq");
    @(negedge clk_i); pin_in_i[3] = 1'b0;
    repeat (3) @(posedge clk_i);
    rd(8, d); chk({16'h0, d}, 32'h8, "R5 falling edge");
    chk({31'h0, irq_o}, 32'h1, "R10 irq raised");
    repeat (10) @(posedge clk_i);
    rd(8, d); chk({16'h0, d}, 32'h8, "R7 held");
    wr(8, 16'h0000); rd(8, d); chk({16'h0, d}, 32'h8, "R9 zero write");
    wr(8, 16'hFFF7); rd(8, d); chk({16'h0, d}, 32'h8, "R9 other bits");
    wr(8, 16'h0008); rd(8, d); chk({16'h0, d}, 32'h0, "R9 cleared");
    chk({31'h0, irq_o}, 32'h0, "R10 irq dropped");
    @(negedge clk_i); pin_in_i[3] = 1'b1;
    repeat (3) @(posedge clk_i);
    rd(8, d); chk({16'h0, d}, 32'h8, "R5 rising edge");
  endtask

  task automatic t_irq_mask;
    wr(6, 16'h0000); chk({31'h0, irq_o}, 32'h0, "R10 masked");
    wr(6, 16'h0008); chk({31'h0, irq_o}, 32'h1, "R10 unmasked");
    wr(8, 16'h0008); chk({31'h0, irq_o}, 32'h0, "R10 after clear");
  endtask

  task automatic t_race;
    logic [15:0] d;
    @(negedge clk_i); pin_in_i[3] = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); pin_in_i[3] = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    wr(8, 16'h0008); // clear lands on the same edge as the new event
    rd(8, d); chk({16'h0, d}, 32'h8, "R9 event wins over clear");
    wr(8, 16'h0008);
    rd(8, d); chk({16'h0, d}, 32'h0, "R9 clear without event");
  endtask

  task automatic t_level;
    logic [15:0] d;
    wr(13, 16'h0010);
    rd(9, d); chk({16'h0, d}, 32'h10, "R6 active-high live");
    @(negedge clk_i); pin_in_i[20] = 1'b0;
    repeat (3) @(posedge clk_i);
    rd(9, d); chk({16'h0, d}, 32'h0, "R8 through follows level");
    wr(15, 16'h0020);
    @(negedge clk_i); pin_in_i[21] = 1'b0;
    repeat (3) @(posedge clk_i);
    rd(9, d); chk({16'h0, d}, 32'h20, "R6 active-low");
    @(negedge clk_i); pin_in_i[21] = 1'b1;
    repeat (4) @(posedge clk_i);
    rd(9, d); chk({16'h0, d}, 32'h20, "R7 level held");
    wr(9, 16'h0020);
    rd(9, d); chk({16'h0, d}, 32'h0, "R9 level clear");
  endtask

  task automatic t_through_edge;
    logic [15:0] d;
    wr(10, 16'h0028);
    @(negedge clk_i); pin_in_i[5] = 1'b0;
    repeat (3) @(posedge clk_i);
    rd(8, d); chk({16'h0, d}, 32'h20, "R8 edge pulse high");
    rd(8, d); chk({16'h0, d}, 32'h0, "R8 edge pulse one cycle");
  endtask

  task automatic t_outpin;
    logic [15:0] d;
    wr(14, 16'h00A8); wr(10, 16'h00A8); wr(4, 16'h0080);
    @(negedge clk_i); pin_in_i[7] = 1'b0;
    repeat (4) @(posedge clk_i);
    rd(8, d); chk({16'h0, d}, 32'h0, "R11 output pin silent");
    wr(2, 16'h0001);
    rd(8, d); chk({16'h0, d}, 32'h0, "R4 hi bank write no status");
    wr(4, 16'h0000);
    rd(8, d); chk({16'h0, d}, 32'h0, "R11 back to input no edge");
  endtask

  task automatic t_warmup;
    logic [15:0] d;
    pin_in_i = '1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int k = 0; k < 5; k++) begin
      rd(8, d); chk({16'h0, d}, 32'h0, "R1 status clear while sync fills");
    end
    chk(pin_oe_o, 32'h0, "R1 oe after second reset");
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (5) @(posedge clk_i);
    t_reset();
    t_halves();
    t_hibank();
    t_pull();
    t_edge_hold();
    t_irq_mask();
    t_race();
    t_level();
    t_through_edge();
    t_outpin();
    t_warmup();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule